// File: doc/BRIEF.md
# AHB-to-APB Bridge

This block sits between a pipelined AHB-style system bus and a slow two-phase APB peripheral bus that share one clock. Toward the system bus it behaves as a slave. Toward the peripheral it behaves as the single APB manager and drives one select line. Every accepted system-bus transfer becomes exactly one APB transfer.

The request is copied into holding registers when it is accepted. The address and direction are taken in the address phase. The write data is taken in the following data-phase cycle. The APB side then runs a SETUP cycle and an ACCESS cycle from those registers only. The upstream ready output stays low until the peripheral completes, so peripheral wait states turn into upstream wait states. A peripheral error that arrives on the completing beat becomes an upstream error response on that same beat.

A transfer offered while the bridge is busy is stalled by the low ready. It is accepted in the cycle the current APB transfer completes.

Top module: `ahb_apb_bridge`

## Requirements
- R1: After a synchronous active-low reset, `ahb_ready_out` is 1, `ahb_resp` is 0 (OKAY), and `apb_sel` and `apb_enable` are both 0.
- R2: A transfer is accepted only when `ahb_sel` is 1, `ahb_trans` is 2'b10 (NONSEQ) or 2'b11 (SEQ), and `ahb_ready_in` is 1. Cycles with `ahb_trans` 2'b00 (IDLE) or 2'b01 (BUSY), or with `ahb_sel` 0, start no APB transfer.
- R3: Each accept is followed by one load cycle (`apb_sel`=0, ready low). Then comes exactly one SETUP cycle (`apb_sel`=1, `apb_enable`=0), and then ACCESS (`apb_sel`=1, `apb_enable`=1). The number of SETUP cycles equals the number of accepts.
- R4: While in ACCESS with `apb_ready` low, the bridge stays in ACCESS and `ahb_ready_out` stays 0.
- R5: `ahb_ready_out` is 1 only in the idle state or on the completing ACCESS beat (`apb_ready`=1). It is 0 in the load and SETUP cycles, whatever `apb_ready` is.
- R6: `ahb_rdata` equals `apb_rdata`, so read data is valid on the completing beat.
- R7: `ahb_resp` is 1 (ERROR) only on the completing ACCESS beat when `apb_err` is 1. In every other cycle it is 0, including wait cycles where `apb_err` is 1.
- R8: `apb_addr`, `apb_write` and `apb_wdata` come from registers loaded at accept (address, direction) and in the load cycle (write data). They stay constant from SETUP to completion while the live AHB bus moves on.
- R9: `apb_enable` returns to 0 after every completing beat, so two APB transfers never abut without a SETUP cycle, even for back-to-back AHB transfers.
- R10: A transfer offered while the bridge is busy is accepted on the completing beat of the current transfer. Its load cycle follows immediately.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for both bus faces |
| rst_n | input | 1 | Synchronous active-low reset |
| ahb_sel | input | 1 | Slave select from the system-bus decoder |
| ahb_trans | input | 2 | Transfer type: 00 idle, 01 busy, 10 nonseq, 11 seq |
| ahb_addr | input | AW | Address-phase address |
| ahb_write | input | 1 | Address-phase direction, 1 = write |
| ahb_wdata | input | DW | Data-phase write data |
| ahb_ready_in | input | 1 | Bus-level ready (end of previous data phase) |
| ahb_ready_out | output | 1 | Bridge ready; low stalls the master |
| ahb_resp | output | 1 | Response, 0 OKAY, 1 ERROR |
| ahb_rdata | output | DW | Read data to the master |
| apb_sel | output | 1 | Peripheral select |
| apb_enable | output | 1 | High in the ACCESS phase |
| apb_addr | output | AW | Held peripheral address |
| apb_write | output | 1 | Held direction |
| apb_wdata | output | DW | Held write data |
| apb_rdata | input | DW | Peripheral read data |
| apb_ready | input | 1 | Peripheral completion, low inserts waits |
| apb_err | input | 1 | Peripheral error, meaningful on the completing beat |

## Verification
The properties assume a well-behaved master. It keeps `ahb_ready_in` tied to the bridge's own ready. It holds its address phase while that ready is low. It drives write data in the cycle after acceptance. The bench's master model follows these rules: it advances only after a sampled high ready, and it fills idle stretches with IDLE, BUSY and deselected NONSEQ cycles. The peripheral model is deliberately hostile outside the completing beat. It holds `apb_ready` and `apb_err` high whenever ACCESS is not active, and it raises `apb_err` during every wait cycle. Early completion or a misplaced error mapping therefore shows up at the ports.

// File: rtl/brg_pkg.sv
// Shared encodings for the AHB-to-APB bridge.
// Assumes the AHB-Lite style single-bit response.
package brg_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOAD   = 2'd1,
        ST_SETUP  = 2'd2,
        ST_ACCESS = 2'd3
    } brg_state_e;

    localparam logic [1:0] TRANS_IDLE   = 2'b00;
    localparam logic [1:0] TRANS_BUSY   = 2'b01;
    localparam logic [1:0] TRANS_NONSEQ = 2'b10;
    localparam logic [1:0] TRANS_SEQ    = 2'b11;

    localparam logic RESP_OKAY  = 1'b0;
    localparam logic RESP_ERROR = 1'b1;
endpackage

// File: rtl/brg_sequencer.sv
// Transfer sequencer: decodes accepts and walks IDLE/LOAD/SETUP/ACCESS.
// Assumes one clock for both faces and a master that holds its address
// phase while ready is low. One accept yields exactly one SETUP+ACCESS.
module brg_sequencer
    import brg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ahb_sel,
    input  logic [1:0] ahb_trans,
    input  logic       ahb_ready_in,
    input  logic       apb_ready,
    output logic       load_req,
    output logic       load_wdata,
    output logic       in_idle,
    output logic       complete,
    output logic       apb_sel,
    output logic       apb_enable
);
    brg_state_e state_q, state_d;
    logic       accept;

    // Accept decode: a real transfer offered while the bus is ready.
    always_comb begin
        accept = ahb_sel && ahb_ready_in &&
                 ((ahb_trans == TRANS_NONSEQ) || (ahb_trans == TRANS_SEQ));
    end

    // Completion and load strobes derived from the current state.
    always_comb begin
        in_idle    = (state_q == ST_IDLE);
        complete   = (state_q == ST_ACCESS) && apb_ready;
        load_req   = accept && (in_idle || complete);
        load_wdata = (state_q == ST_LOAD);
    end

    // Next-state logic: only a fresh accept re-enters LOAD.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (load_req) state_d = ST_LOAD;
            ST_LOAD:   state_d = ST_SETUP;
            ST_SETUP:  state_d = ST_ACCESS;
            ST_ACCESS: if (apb_ready) state_d = load_req ? ST_LOAD : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // APB phase outputs: enable only in ACCESS, so it drops between transfers.
    always_comb begin
        apb_sel    = (state_q == ST_SETUP) || (state_q == ST_ACCESS);
        apb_enable = (state_q == ST_ACCESS);
    end
endmodule

// File: rtl/brg_hold_regs.sv
// Holding registers that freeze the request across the APB transfer.
// Address and direction load on accept; write data loads one cycle later,
// in the AHB data phase. APB request outputs come only from here.
module brg_hold_regs #(
    parameter int AW = 12,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_req,
    input  logic          load_wdata,
    input  logic [AW-1:0] ahb_addr,
    input  logic          ahb_write,
    input  logic [DW-1:0] ahb_wdata,
    output logic [AW-1:0] apb_addr,
    output logic          apb_write,
    output logic [DW-1:0] apb_wdata
);
    // Address-phase capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            apb_addr  <= '0;
            apb_write <= 1'b0;
        end else if (load_req) begin
            apb_addr  <= ahb_addr;
            apb_write <= ahb_write;
        end
    end

    // Data-phase capture of write data.
    always_ff @(posedge clk) begin
        if (!rst_n)          apb_wdata <= '0;
        else if (load_wdata) apb_wdata <= ahb_wdata;
    end
endmodule

// File: rtl/brg_resp.sv
// Upstream response mapping: ready and error follow the APB completion beat
// only; read data passes straight through from the peripheral.
module brg_resp
    import brg_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          in_idle,
    input  logic          complete,
    input  logic          apb_err,
    input  logic [DW-1:0] apb_rdata,
    output logic          ahb_ready_out,
    output logic          ahb_resp,
    output logic [DW-1:0] ahb_rdata
);
    // Ready, response and data toward the master.
    always_comb begin
        ahb_ready_out = in_idle || complete;
        ahb_resp      = (complete && apb_err) ? RESP_ERROR : RESP_OKAY;
        ahb_rdata     = apb_rdata;
    end
endmodule

// File: rtl/ahb_apb_bridge.sv
// AHB-slave to APB-manager bridge, single clock, single peripheral select.
// Assumes ahb_ready_in reflects the shared bus ready and that the master
// drives write data in the cycle after its accepted address phase.
module ahb_apb_bridge #(
    parameter int AW = 12,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ahb_sel,
    input  logic [1:0]    ahb_trans,
    input  logic [AW-1:0] ahb_addr,
    input  logic          ahb_write,
    input  logic [DW-1:0] ahb_wdata,
    input  logic          ahb_ready_in,
    output logic          ahb_ready_out,
    output logic          ahb_resp,
    output logic [DW-1:0] ahb_rdata,
    output logic          apb_sel,
    output logic          apb_enable,
    output logic [AW-1:0] apb_addr,
    output logic          apb_write,
    output logic [DW-1:0] apb_wdata,
    input  logic [DW-1:0] apb_rdata,
    input  logic          apb_ready,
    input  logic          apb_err
);
    logic load_req, load_wdata, in_idle, complete;

    brg_sequencer u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .ahb_sel      (ahb_sel),
        .ahb_trans    (ahb_trans),
        .ahb_ready_in (ahb_ready_in),
        .apb_ready    (apb_ready),
        .load_req     (load_req),
        .load_wdata   (load_wdata),
        .in_idle      (in_idle),
        .complete     (complete),
        .apb_sel      (apb_sel),
        .apb_enable   (apb_enable)
    );

    brg_hold_regs #(.AW(AW), .DW(DW)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_req   (load_req),
        .load_wdata (load_wdata),
        .ahb_addr   (ahb_addr),
        .ahb_write  (ahb_write),
        .ahb_wdata  (ahb_wdata),
        .apb_addr   (apb_addr),
        .apb_write  (apb_write),
        .apb_wdata  (apb_wdata)
    );

    brg_resp #(.DW(DW)) u_resp (
        .in_idle       (in_idle),
        .complete      (complete),
        .apb_err       (apb_err),
        .apb_rdata     (apb_rdata),
        .ahb_ready_out (ahb_ready_out),
        .ahb_resp      (ahb_resp),
        .ahb_rdata     (ahb_rdata)
    );
endmodule

// File: rtl/ahb_apb_bridge_chk.sv
// Cross-boundary checker for the bridge, bound to the top module.
// Relates the upstream handshake to the APB phases at the ports.
module ahb_apb_bridge_chk #(
    parameter int AW = 12,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ahb_sel,
    input logic [1:0]    ahb_trans,
    input logic          ahb_ready_in,
    input logic          ahb_ready_out,
    input logic          ahb_resp,
    input logic          apb_sel,
    input logic          apb_enable,
    input logic [AW-1:0] apb_addr,
    input logic          apb_write,
    input logic [DW-1:0] apb_wdata,
    input logic          apb_ready,
    input logic          apb_err
);
    logic acc;
    assign acc = ahb_sel && ahb_trans[1] && ahb_ready_in;

    p_ignore_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ahb_ready_out && !acc) |=> (ahb_ready_out && !apb_sel));

    p_accept_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ahb_ready_out && acc) |=> (!ahb_ready_out && !apb_sel));

    p_setup_then_access_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (apb_sel && !apb_enable) |=> (apb_sel && apb_enable));

    p_wait_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (apb_sel && apb_enable && !apb_ready) |-> !ahb_ready_out);

    p_wait_stay_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (apb_sel && apb_enable && !apb_ready) |=> (apb_sel && apb_enable));

    p_setup_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (apb_sel && !apb_enable) |-> !ahb_ready_out);

    p_err_only_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ahb_resp |-> (apb_sel && apb_enable && apb_ready && apb_err));

    p_err_mapped_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (apb_sel && apb_enable && apb_ready && apb_err) |-> ahb_resp);

    p_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (apb_sel && !(apb_enable && apb_ready)) |=>
        ($stable(apb_addr) && $stable(apb_write) && $stable(apb_wdata)));

    p_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (apb_sel && apb_enable && apb_ready) |=> !apb_enable);
endmodule

bind ahb_apb_bridge ahb_apb_bridge_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/ahb_apb_bridge_tb_top.sv
module ahb_apb_bridge_tb_top;
    localparam int AW  = 12;
    localparam int DW  = 32;
    localparam int NTR = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ahb_sel = 1'b0;
    logic [1:0]    ahb_trans = 2'b00;
    logic [AW-1:0] ahb_addr = '0;
    logic          ahb_write = 1'b0;
    logic [DW-1:0] ahb_wdata = '0;
    logic          ahb_ready_in;
    logic          ahb_ready_out, ahb_resp, apb_sel, apb_enable, apb_write;
    logic [DW-1:0] ahb_rdata, apb_wdata;
    logic [AW-1:0] apb_addr;
    logic [DW-1:0] apb_rdata = '0;
    logic          apb_ready = 1'b1;
    logic          apb_err = 1'b0;

    always #4 clk = ~clk;
    assign ahb_ready_in = ahb_ready_out;

    ahb_apb_bridge #(.AW(AW), .DW(DW)) dut_i (.*);

    int n_chk = 0, n_fail = 0;
    int m_ph = 0;               // model phase: 0 idle, 1 load, 2 setup, 3 access
    logic [AW-1:0] m_addr = '0;
    logic          m_wr = 1'b0;
    logic [DW-1:0] m_wd = '0;
    logic          hr_at_edge = 1'b1;
    int s_idx = 0, s_wc = 0, n_b2b = 0, n_setup = 0;
    int ti = 0, gap_left = 0, aph_idx = 0, cyc = 0;
    logic aph_act = 1'b0;

    function automatic logic [AW-1:0] t_addr(int i); return AW'(32'h40 + i * 8); endfunction
    function automatic logic t_wr(int i); return (i % 3) != 1; endfunction
    function automatic logic [DW-1:0] t_data(int i); return 32'hC0DE_0000 + i * 32'h111; endfunction
    function automatic logic [DW-1:0] t_rd(int i); return 32'h5A00_0000 | i; endfunction
    function automatic int t_gap(int i); return (i % 4 == 1) ? 3 : ((i % 4 == 3) ? 1 : 0); endfunction
    function automatic int t_wait(int i); return (i * 3) % 4; endfunction
    function automatic logic t_err(int i); return (i % 5) == 2; endfunction

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Behavioural reference and bench-side slave/master bookkeeping.
    always @(posedge clk) begin
        hr_at_edge <= ahb_ready_out;
        if (!rst_n) begin
            m_ph <= 0;
        end else begin
            if (m_ph == 1) m_wd <= ahb_wdata;
            if ((m_ph == 0 || (m_ph == 3 && apb_ready)) && ahb_sel && ahb_trans[1]) begin
                if (m_ph == 3) n_b2b <= n_b2b + 1;
                m_ph <= 1; m_addr <= ahb_addr; m_wr <= ahb_write;
            end else if (m_ph == 3) begin
                if (apb_ready) m_ph <= 0;
            end else if (m_ph != 0) begin
                m_ph <= m_ph + 1;
            end
            if (apb_sel && apb_enable) begin
                if (apb_ready) begin s_idx <= s_idx + 1; s_wc <= 0; end
                else s_wc <= s_wc + 1;
            end
        end
    end

    task automatic drive_master();
        if (!hr_at_edge) return;
        if (aph_act) ahb_wdata = t_wr(aph_idx) ? t_data(aph_idx) : (32'hBAD0_0000 | aph_idx);
        else         ahb_wdata = 32'h0BAD_BEEF ^ cyc;
        if (ti < NTR && gap_left == 0) begin
            ahb_sel = 1'b1; ahb_trans = (ti % 2) ? 2'b11 : 2'b10;
            ahb_addr = t_addr(ti); ahb_write = t_wr(ti);
            aph_act = 1'b1; aph_idx = ti; ti++;
            gap_left = (ti < NTR) ? t_gap(ti) : 0;
        end else begin
            aph_act = 1'b0;
            ahb_addr = AW'(cyc * 7); ahb_write = ~ahb_write;
            case (gap_left % 3)
                0: begin ahb_sel = 1'b1; ahb_trans = 2'b00; end
                1: begin ahb_sel = 1'b1; ahb_trans = 2'b01; end
                default: begin ahb_sel = 1'b0; ahb_trans = 2'b10; end
            endcase
            if (gap_left > 0) gap_left--;
        end
    endtask

    task automatic drive_slave();
        if (apb_sel && apb_enable) begin
            if (s_wc >= t_wait(s_idx)) begin
                apb_ready = 1'b1; apb_rdata = t_rd(s_idx); apb_err = t_err(s_idx);
            end else begin
                apb_ready = 1'b0; apb_rdata = 32'hDEAD_0000 | s_wc; apb_err = 1'b1;
            end
        end else begin
            apb_ready = 1'b1; apb_err = 1'b1; apb_rdata = 32'hFFFF_FFFF;
        end
    endtask

    task automatic compare();
        logic done;
        done = (m_ph == 3) && apb_ready;
        chk("R3", "apb_sel", 32'(apb_sel), 32'(m_ph >= 2));
        chk("R9", "apb_enable", 32'(apb_enable), 32'(m_ph == 3));
        if (m_ph == 3 && !apb_ready) chk("R4", "ahb_ready_out wait", 32'(ahb_ready_out), 32'(0));
        else chk("R5", "ahb_ready_out", 32'(ahb_ready_out), 32'(m_ph == 0 || done));
        chk("R7", "ahb_resp", 32'(ahb_resp), 32'(done && apb_err));
        if (m_ph >= 2) begin
            chk("R8", "apb_addr", 32'(apb_addr), 32'(m_addr));
            chk("R8", "apb_write", 32'(apb_write), 32'(m_wr));
            chk("R8", "apb_wdata", apb_wdata, m_wd);
        end
        if (apb_sel && !apb_enable) n_setup++;
        if (apb_sel && apb_enable && apb_ready) begin
            chk("R8", "end-to-end addr", 32'(apb_addr), 32'(t_addr(s_idx)));
            chk("R8", "end-to-end dir", 32'(apb_write), 32'(t_wr(s_idx)));
            if (t_wr(s_idx)) chk("R8", "end-to-end wdata", apb_wdata, t_data(s_idx));
            chk("R6", "ahb_rdata", ahb_rdata, t_rd(s_idx));
            chk("R7", "error beat", 32'(ahb_resp), 32'(t_err(s_idx)));
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "reset ready", 32'(ahb_ready_out), 32'(1));
        chk("R1", "reset resp", 32'(ahb_resp), 32'(0));
        chk("R1", "reset sel", 32'(apb_sel), 32'(0));
        chk("R1", "reset enable", 32'(apb_enable), 32'(0));
        rst_n = 1'b1;
        forever begin
            @(negedge clk);
            cyc++;
            drive_master();
            drive_slave();
            #3;
            compare();
            if (ti == NTR && s_idx == NTR && m_ph == 0) break;
            if (cyc > 5000) begin
                n_fail++;
                $display("FAIL R3 watchdog actual=%0d expected=%0d", s_idx, NTR);
                break;
            end
        end
        repeat (4) begin @(negedge clk); drive_master(); drive_slave(); #3; compare(); end
        chk("R2", "setup count", 32'(n_setup), 32'(NTR));
        chk("R3", "completions", 32'(s_idx), 32'(NTR));
        chk("R10", "back-to-back accepts seen", 32'(n_b2b > 0), 32'(1));
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule